// File: doc/BRIEF.md
# Elastic buffer release controller

This block decides the single clock cycle in which every receive lane buffer of a multi-lane serial receiver starts to be read, so that the latency through the link is the same after every startup. Each lane reports when its aligned data has started to arrive. The local multiframe clock supplies a strobe for each frame and a strobe for each multiframe boundary. Two configuration inputs set the frames per multiframe and the release offset. The release is not issued when the last lane arrives. It is held back to a fixed frame position inside the multiframe and is issued only when every lane is present.

The controller is a three-state machine with the states `ST_UNARMED`, `ST_ARMED` and `ST_RELEASED`.
- `ST_UNARMED` is the state after reset. The first multiframe strobe takes it to `ST_ARMED` (transition "arm").
- In `ST_ARMED`, a release point with all lanes present takes it to `ST_RELEASED` (transition "release") and produces a one-cycle pulse. A release point with a lane still missing keeps it in `ST_ARMED` (transition "miss") and raises a sticky late-lane flag. The next chance then comes one multiframe later.
- `ST_RELEASED` is left only by reset.

An offset outside the legal range is replaced by the frames-per-multiframe value, and a configuration-error flag is raised.

Top module: `ebuf_release_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `release_pulse`, `late_lane` and `cfg_err` are 0 and the controller is in `ST_UNARMED`.
- R2: No release occurs before the first `lmfc_edge` after reset. The frame that carries that arming edge is never a release point, even when all lanes have already arrived.
- R3: Frames are indexed from the last `lmfc_edge`, and the frame that carries the edge has index 0. A release point is a `frame_strobe` whose index equals the offset, except that an offset equal to `cfg_k` selects index 0, which is the multiframe edge itself.
- R4: `release_pulse` is exactly one cycle wide. It is high in the cycle after the clock edge that samples the release-point strobe.
- R5: A release point at which any lane has not yet arrived produces no pulse. The release then happens at the first later release point, one or more multiframes on, at which all lanes are present.
- R6: A lane counts as arrived from the cycle its `lane_arrived` bit is first high until reset, even if the bit falls again afterwards.
- R7: After the pulse, no further pulse occurs until reset, whatever strobes follow.
- R8: A `cfg_rbd` of 0 or greater than `cfg_k` sets `cfg_err`, one cycle after it is applied, and the offset used is then `cfg_k`. For values from 1 to `cfg_k`, `cfg_err` is 0.
- R9: `late_lane` rises in the cycle after a release point is missed and stays high until reset. It stays 0 when the release happens at the first release point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet-rate clock |
| rst_n | input | 1 | Asynchronous link reset, active low |
| lane_arrived | input | NUM_LANES | Per-lane indication that aligned data has begun arriving |
| frame_strobe | input | 1 | One-cycle strobe at the start of every frame |
| lmfc_edge | input | 1 | One-cycle strobe at each multiframe boundary, coincident with a frame strobe |
| cfg_k | input | CFG_W | Frames per multiframe (1 or more) |
| cfg_rbd | input | CFG_W | Release offset in frames |
| release_pulse | output | 1 | One-cycle start-reading pulse shared by all lane buffers |
| late_lane | output | 1 | Sticky flag: a release point was missed because a lane was absent |
| cfg_err | output | 1 | Offset outside 1..`cfg_k`; `cfg_k` used instead |

## Verification
The assertions assume that every multiframe strobe falls on a frame strobe, that `cfg_k` is nonzero, and that both configuration values are held steady while the link runs. The stimulus meets these assumptions by construction. It generates the strobes from one cycle counter with a fixed frame length, and it applies the configuration only while reset is asserted. The sweep covers every offset from 0 to `cfg_k`+1 and every arrival frame of the slowest lane across two multiframes. It rotates which lane is the slowest, and it alternates between held and one-cycle arrival indications.

// File: rtl/ebr_pkg.sv
package ebr_pkg;
    typedef enum logic [1:0] {
        ST_UNARMED  = 2'd0,
        ST_ARMED    = 2'd1,
        ST_RELEASED = 2'd2
    } ebr_state_e;
endpackage

// File: rtl/ebr_cfg_check.sv
module ebr_cfg_check #(
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_k,
    input  logic [CFG_W-1:0] cfg_rbd,
    output logic [CFG_W-1:0] target_idx,
    output logic             cfg_err
);
    logic             bad_rbd;
    logic [CFG_W-1:0] eff_rbd;

    always_comb begin
        bad_rbd    = (cfg_rbd == '0) || (cfg_rbd > cfg_k);
        eff_rbd    = bad_rbd ? cfg_k : cfg_rbd;
        // an offset of K lands on the multiframe edge, which is index 0
        target_idx = (eff_rbd == cfg_k) ? '0 : eff_rbd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_err <= 1'b0;
        else        cfg_err <= bad_rbd;
    end

    // R8: the index used for release never lies outside the multiframe
    assert_target_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_k != '0) |-> (target_idx < cfg_k));
endmodule

// File: rtl/ebr_frame_ctr.sv
module ebr_frame_ctr #(
    parameter int CFG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_strobe,
    input  logic             lmfc_edge,
    input  logic [CFG_W-1:0] target_idx,
    output logic             rel_point
);
    logic [CFG_W-1:0] idx_q;
    logic [CFG_W-1:0] idx_now;

    always_comb begin
        idx_now   = lmfc_edge ? '0 : idx_q + 1'b1;
        rel_point = frame_strobe && (idx_now == target_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            idx_q <= '0;
        else if (frame_strobe) idx_q <= idx_now;
    end

    // R3: the multiframe boundary always coincides with a frame start
    assert_lmfc_on_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lmfc_edge |-> frame_strobe);
endmodule

// File: rtl/ebr_lane_gate.sv
module ebr_lane_gate #(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_arrived,
    output logic                 all_arrived
);
    logic [NUM_LANES-1:0] seen_q;
    logic [NUM_LANES-1:0] present;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               seen_q[g] <= 1'b0;
            else if (lane_arrived[g]) seen_q[g] <= 1'b1;
        end
        assign present[g] = seen_q[g] | lane_arrived[g];
    end

    assign all_arrived = &present;

    // R6: once every lane is present, none drops out again
    assert_arrival_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        all_arrived |=> all_arrived);
endmodule

// File: rtl/ebuf_release_ctrl.sv
module ebuf_release_ctrl
    import ebr_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int CFG_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_arrived,
    input  logic                 frame_strobe,
    input  logic                 lmfc_edge,
    input  logic [CFG_W-1:0]     cfg_k,
    input  logic [CFG_W-1:0]     cfg_rbd,
    output logic                 release_pulse,
    output logic                 late_lane,
    output logic                 cfg_err
);
    logic [CFG_W-1:0] target_idx;
    logic             rel_point;
    logic             all_arrived;
    ebr_state_e       state_q, state_d;
    logic             fire, miss;

    ebr_cfg_check #(.CFG_W(CFG_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_k(cfg_k), .cfg_rbd(cfg_rbd),
        .target_idx(target_idx), .cfg_err(cfg_err)
    );

    ebr_frame_ctr #(.CFG_W(CFG_W)) u_fctr (
        .clk(clk), .rst_n(rst_n), .frame_strobe(frame_strobe),
        .lmfc_edge(lmfc_edge), .target_idx(target_idx), .rel_point(rel_point)
    );

    ebr_lane_gate #(.NUM_LANES(NUM_LANES)) u_gate (
        .clk(clk), .rst_n(rst_n), .lane_arrived(lane_arrived),
        .all_arrived(all_arrived)
    );

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        miss    = 1'b0;
        unique case (state_q)
            ST_UNARMED:  if (lmfc_edge) state_d = ST_ARMED;
            ST_ARMED: begin
                if (rel_point) begin
                    if (all_arrived) begin
                        fire    = 1'b1;
                        state_d = ST_RELEASED;
                    end else begin
                        miss    = 1'b1;
                    end
                end
            end
            ST_RELEASED: state_d = ST_RELEASED;
            default:     state_d = ST_UNARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_UNARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            release_pulse <= 1'b0;
            late_lane     <= 1'b0;
        end else begin
            release_pulse <= fire;
            late_lane     <= late_lane | miss;
        end
    end

    assert_one_wide_R4: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |=> !release_pulse);

    assert_after_all_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> $past(all_arrived));

    assert_on_release_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> $past(rel_point));

    assert_armed_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        release_pulse |-> $past(state_q == ST_ARMED));

    assert_no_second_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RELEASED && $past(state_q == ST_RELEASED)) |-> !release_pulse);

    assert_late_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        late_lane |=> late_lane);
endmodule

// File: tb/sim_ebuf_release_ctrl.sv
module sim_ebuf_release_ctrl;
    localparam int NL    = 4;
    localparam int CW    = 4;
    localparam int KVAL  = 4;
    localparam int FLEN  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] lane_arrived = '0;
    logic          frame_strobe = 1'b0;
    logic          lmfc_edge = 1'b0;
    logic [CW-1:0] cfg_k = CW'(KVAL);
    logic [CW-1:0] cfg_rbd = '0;
    logic          release_pulse, late_lane, cfg_err;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    ebuf_release_ctrl #(.NUM_LANES(NL), .CFG_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .lane_arrived(lane_arrived),
        .frame_strobe(frame_strobe), .lmfc_edge(lmfc_edge),
        .cfg_k(cfg_k), .cfg_rbd(cfg_rbd),
        .release_pulse(release_pulse), .late_lane(late_lane), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired: actual=%0d cycles expected<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            failures = failures + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_scn(input int rbd, input int arr, input int slow, input bit pulsed);
        int tgt, first_pt, grel, ncyc, pcnt, pcyc;
        bit bad;
        bad = (rbd == 0) || (rbd > KVAL);
        tgt = bad ? 0 : (rbd % KVAL);
        first_pt = (tgt == 0) ? KVAL : tgt;
        grel = first_pt;
        while (grel < arr) grel = grel + KVAL;
        ncyc = (arr + 2 * KVAL + 1) * FLEN;

        @(negedge clk);
        rst_n = 1'b0;
        cfg_rbd = CW'(rbd);
        lane_arrived = '0;
        frame_strobe = 1'b0;
        lmfc_edge = 1'b0;
        @(negedge clk);
        check("R1 reset pulse", int'(release_pulse), 0);
        check("R1 reset late", int'(late_lane), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset cfg_err", int'(cfg_err), int'(bad));
        // R2: idle frames with lanes present but no multiframe edge
        for (int i = 0; i < 3; i++) begin
            frame_strobe = 1'b1;
            lane_arrived = '1;
            @(negedge clk);
            frame_strobe = 1'b0;
            if (release_pulse) check("R2 release before arm", 1, 0);
        end
        lane_arrived = '0;
        @(negedge clk);
        // R1: the arrivals above were taken into the state, so reset again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        pcnt = 0;
        pcyc = -1;
        for (int c = 0; c < ncyc; c++) begin
            frame_strobe = (c % FLEN) == 0;
            lmfc_edge = (c % (FLEN * KVAL)) == 0;
            for (int l = 0; l < NL; l++) begin
                if (l != slow) lane_arrived[l] = 1'b1;
                else if (pulsed) lane_arrived[l] = (c == arr * FLEN);
                else lane_arrived[l] = (c >= arr * FLEN);
            end
            @(posedge clk);
            @(negedge clk);
            if (release_pulse) begin
                pcnt = pcnt + 1;
                if (pcyc < 0) pcyc = c;
            end
        end
        frame_strobe = 1'b0;
        lmfc_edge = 1'b0;
        // R3 R5 R6: pulse follows the computed release frame
        check("R3/R5/R6 release cycle", pcyc, grel * FLEN);
        // R4 R7: exactly one pulse cycle overall
        check("R4/R7 pulse count", pcnt, 1);
        check("R9 late flag", int'(late_lane), int'(grel != first_pt));
        check("R8 cfg_err", int'(cfg_err), int'(bad));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 initial pulse", int'(release_pulse), 0);
        check("R1 initial cfg_err", int'(cfg_err), 0);
        for (int r = 0; r <= KVAL + 1; r++)
            for (int a = 0; a <= 2 * KVAL; a++)
                run_scn(r, a, (r + a) % NL, ((r + a) % 2) == 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule